// File: doc/BRIEF.md
# Melody step sequencer with tempo

This block plays one tune out of a shared step memory. When play is raised it latches the tune index, tempo code and prescale choice. It then reads the tune's start address from a header slot indexed by the tune number and walks the tune's steps through a synchronous read port.

Each step is a note or a rest and carries a 3-bit length code. A prescaler, a tempo divider and a rhythm counter time each step. The current pitch code goes to an external tone generator, along with a note/rest indication and a one-cycle strike pulse that marks each new articulation. Tied steps merge into one held note. An end-of-tune code sends the walk back to the start address, and the tune repeats for as long as play stays high.

Top module: `melody_stepper`

## Requirements
- R1: When play is first seen high, the block reads address `tune_sel` (zero-extended), takes bits [ADDR_W-1:0] of the returned word as the start address, and reads the first step there. The outputs of the first step appear at the fourth clock edge after the edge that sampled play high.
- R2: A step word has the length code in bits [2:0], the tie flag in bit 3 and the pitch code in bits [PITCH_W+3:4]. Pitch 0 is a rest, all ones is the end-of-tune marker, and any other value is a note whose code appears on `pitch`.
- R3: Length codes 0..7 last 1, 2, 3, 4, 6, 8, 12 and 16 sixteenth units, where one unit is QUARTER/4 tempo ticks. A step's outputs are held for units·(QUARTER/4)·(T+1)·P + 2 clock cycles.
- R4: The prescale period P is PRE_DIV·2 clock cycles when `div_sel` is 0 and PRE_DIV·4 when it is 1.
- R5: The tempo divider divides the prescaled tick by `tempo_code`+1 (T = tempo_code).
- R6: During a rest, `rest_on` is 1, `note_on` is 0 and `pitch` is 0. `note_on` and `rest_on` are never high together.
- R7: `strike` pulses high for exactly one cycle on the first cycle of every note, except a note that directly follows a note whose tie flag is set. A tied pair keeps `note_on` high across the step boundary.
- R8: An end-of-tune step reloads the start address and costs 2 extra cycles, during which the previous step's outputs are held. The tune then repeats from its first step.
- R9: If play is low at a clock edge, all counters reset and `pitch`, `note_on`, `rest_on` and `strike` are 0 after that edge.
- R10: Tune index, tempo code and prescale choice are sampled only when play starts. Changes during play have no effect on the tune being played or on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| play | input | 1 | Play enable; high plays and loops, low stops |
| tune_sel | input | TUNE_W | Tune index, sampled at play start |
| tempo_code | input | TEMPO_W | Tempo divider code T, divide by T+1 |
| div_sel | input | 1 | Prescale choice: 0 selects PRE_DIV·2, 1 selects PRE_DIV·4 |
| mem_addr | output | ADDR_W | Step memory read address |
| mem_rdata | input | PITCH_W+4 | Step memory read data, valid one cycle after the address |
| pitch | output | PITCH_W | Current pitch code for the tone generator |
| note_on | output | 1 | A note is sounding |
| rest_on | output | 1 | A rest is in progress |
| strike | output | 1 | One-cycle pulse at each new articulation |

## Verification
The bench times each step to the exact cycle at both its first and last cycle. A counter chain that is off by one, or a wrong entry in the length table, moves an edge and is caught. It plays a tied pair after an untied note and a rest. A design that re-articulates tied notes would raise `strike` on the second note, and one that drops `note_on` in the fetch gap would show silence there. It lets the tune wrap past its end marker to check the two-cycle reload and the repeat. It changes the tune, tempo and prescale inputs in mid-play, so a design that tracks them live would change pitch or timing. Separate runs at a higher tempo code and with the longer prescale check the divider arithmetic, and a mid-note stop checks that the outputs clear at once.

// File: rtl/melody_stepper.sv
module melody_stepper #(
  parameter int ADDR_W  = 9,
  parameter int TUNE_W  = 4,
  parameter int PITCH_W = 5,
  parameter int TEMPO_W = 5,
  parameter int PRE_DIV = 128,
  parameter int QUARTER = 1536
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 play,
  input  logic [TUNE_W-1:0]    tune_sel,
  input  logic [TEMPO_W-1:0]   tempo_code,
  input  logic                 div_sel,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic [PITCH_W+3:0]   mem_rdata,
  output logic [PITCH_W-1:0]   pitch,
  output logic                 note_on,
  output logic                 rest_on,
  output logic                 strike
);
  localparam int PW   = $clog2(PRE_DIV * 4);
  localparam int RW   = $clog2(QUARTER * 4 + 1);
  localparam int UNIT = QUARTER / 4;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_HDRW, S_FETCH, S_LOAD, S_PLAY} state_t;
  state_t state;

  logic [TUNE_W-1:0]  tune_q;
  logic [TEMPO_W-1:0] tempo_q;
  logic               div_q;
  logic [ADDR_W-1:0]  start_q, ptr;
  logic [PITCH_W-1:0] pitch_q;
  logic               valid, tie_q, strike_q;
  logic [PW-1:0]      pre_cnt;
  logic [TEMPO_W-1:0] tmp_cnt;
  logic [RW-1:0]      rhy_cnt, rhy_last;

  function automatic logic [RW-1:0] units(input logic [2:0] code);
    case (code)
      3'd0: units = RW'(UNIT);
      3'd1: units = RW'(UNIT * 2);
      3'd2: units = RW'(UNIT * 3);
      3'd3: units = RW'(UNIT * 4);
      3'd4: units = RW'(UNIT * 6);
      3'd5: units = RW'(UNIT * 8);
      3'd6: units = RW'(UNIT * 12);
      default: units = RW'(UNIT * 16);
    endcase
  endfunction

  wire [PITCH_W-1:0] w_pitch = mem_rdata[PITCH_W+3:4];
  wire               w_tie   = mem_rdata[3];
  wire [2:0]         w_len   = mem_rdata[2:0];
  wire               w_end   = &w_pitch;

  wire [PW-1:0] pre_top   = div_q ? PW'(PRE_DIV * 4 - 1) : PW'(PRE_DIV * 2 - 1);
  wire          pre_tick  = pre_cnt == pre_top;
  wire          tmp_tick  = pre_tick && (tmp_cnt == tempo_q);
  wire          step_done = tmp_tick && (rhy_cnt == rhy_last);

  assign mem_addr = (state == S_HDR) ? ADDR_W'(tune_q) : ptr;
  assign pitch    = pitch_q;
  assign note_on  = valid && (pitch_q != '0);
  assign rest_on  = valid && (pitch_q == '0);
  assign strike   = strike_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tune_q   <= '0;
      tempo_q  <= '0;
      div_q    <= 1'b0;
      start_q  <= '0;
      ptr      <= '0;
      pitch_q  <= '0;
      valid    <= 1'b0;
      tie_q    <= 1'b0;
      strike_q <= 1'b0;
      pre_cnt  <= '0;
      tmp_cnt  <= '0;
      rhy_cnt  <= '0;
      rhy_last <= '0;
    end else if (!play) begin
      state    <= S_IDLE;
      ptr      <= '0;
      pitch_q  <= '0;
      valid    <= 1'b0;
      tie_q    <= 1'b0;
      strike_q <= 1'b0;
      pre_cnt  <= '0;
      tmp_cnt  <= '0;
      rhy_cnt  <= '0;
    end else begin
      strike_q <= 1'b0;
      case (state)
        S_IDLE: begin
          tune_q  <= tune_sel;
          tempo_q <= tempo_code;
          div_q   <= div_sel;
          state   <= S_HDR;
        end
        S_HDR:  state <= S_HDRW;
        S_HDRW: begin
          start_q <= mem_rdata[ADDR_W-1:0];
          ptr     <= mem_rdata[ADDR_W-1:0];
          state   <= S_FETCH;
        end
        S_FETCH: state <= S_LOAD;
        S_LOAD: begin
          if (w_end) begin
            ptr   <= start_q;
            state <= S_FETCH;
          end else begin
            pitch_q  <= w_pitch;
            valid    <= 1'b1;
            strike_q <= (w_pitch != '0) && !(tie_q && valid && (pitch_q != '0));
            tie_q    <= w_tie;
            rhy_last <= units(w_len) - RW'(1);
            pre_cnt  <= '0;
            tmp_cnt  <= '0;
            rhy_cnt  <= '0;
            state    <= S_PLAY;
          end
        end
        S_PLAY: begin
          pre_cnt <= pre_tick ? '0 : pre_cnt + PW'(1);
          if (pre_tick) tmp_cnt <= tmp_tick ? '0 : tmp_cnt + TEMPO_W'(1);
          if (tmp_tick) rhy_cnt <= rhy_cnt + RW'(1);
          if (step_done) begin
            ptr   <= ptr + ADDR_W'(1);
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module melody_stepper_chk #(
  parameter int PITCH_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               play,
  input logic [PITCH_W-1:0] pitch,
  input logic               note_on,
  input logic               rest_on,
  input logic               strike
);
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(note_on && rest_on));

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !play |=> (!note_on && !rest_on && !strike && pitch == '0));

  a_r7_strike_on_note: assert property (@(posedge clk) disable iff (!rst_n)
    strike |-> note_on);

  a_r7_strike_single: assert property (@(posedge clk) disable iff (!rst_n)
    strike |=> !strike);

  a_r2_no_end_code: assert property (@(posedge clk) disable iff (!rst_n)
    note_on |-> pitch != {PITCH_W{1'b1}});

  a_r1_quiet_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play) |=> (!note_on && !rest_on));
endmodule

bind melody_stepper melody_stepper_chk #(.PITCH_W(PITCH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .play(play), .pitch(pitch),
  .note_on(note_on), .rest_on(rest_on), .strike(strike)
);

// File: tb/test_melody_stepper.sv
module test_melody_stepper;
  localparam int ADDR_W = 9, TUNE_W = 4, PITCH_W = 5, TEMPO_W = 5;
  localparam int PRE_DIV = 2, QUARTER = 8;
  localparam int NS = 5;
  // {pitch[10:6], tie[5], len[4:2], strike_exp[1], note_exp[0]}
  localparam logic [10:0] TUNE_A [NS] = '{
    {5'd5, 1'b0, 3'd3, 1'b1, 1'b1},
    {5'd0, 1'b0, 3'd0, 1'b0, 1'b0},
    {5'd7, 1'b1, 3'd1, 1'b1, 1'b1},
    {5'd7, 1'b0, 3'd2, 1'b0, 1'b1},
    {5'd9, 1'b0, 3'd7, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, play = 1'b0, div_sel = 1'b0;
  logic [TUNE_W-1:0] tune_sel = '0;
  logic [TEMPO_W-1:0] tempo_code = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic [PITCH_W+3:0] mem_rdata;
  logic [PITCH_W-1:0] pitch;
  logic note_on, rest_on, strike;
  logic [PITCH_W+3:0] mem [512];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;
  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  melody_stepper #(.ADDR_W(ADDR_W), .TUNE_W(TUNE_W), .PITCH_W(PITCH_W), .TEMPO_W(TEMPO_W),
                   .PRE_DIV(PRE_DIV), .QUARTER(QUARTER)) i_melody_stepper (
    .clk(clk), .rst_n(rst_n), .play(play), .tune_sel(tune_sel), .tempo_code(tempo_code),
    .div_sel(div_sel), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pitch(pitch),
    .note_on(note_on), .rest_on(rest_on), .strike(strike));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int units(input int code);
    int t [8] = '{1, 2, 3, 4, 6, 8, 12, 16};
    return t[code] * (QUARTER / 4);
  endfunction

  task automatic start(input int tune, input int tempo, input logic dv);
    tune_sel = TUNE_W'(tune); tempo_code = TEMPO_W'(tempo); div_sel = dv;
    play = 1'b1;
    negs(5);
  endtask

  task automatic stop_play();
    play = 1'b0;
    negs(2);
  endtask

  initial begin
    for (int a = 0; a < 512; a++) mem[a] = '0;
    mem[2] = 9'd32;
    for (int i = 0; i < NS; i++) mem[32 + i] = TUNE_A[i][10:2];
    mem[32 + NS] = {5'h1F, 4'd0};
    mem[3] = 9'd64;
    mem[64] = {5'd3, 1'b0, 3'd0};
    mem[65] = {5'h1F, 4'd0};

    negs(2);
    check("R9 reset pitch", int'(pitch), 0);
    check("R9 reset note_on", int'(note_on), 0);
    check("R9 reset rest_on", int'(rest_on), 0);
    check("R9 reset strike", int'(strike), 0);
    rst_n = 1'b1;
    negs(2);

    start(2, 0, 1'b0);
    for (int lap = 0; lap < 2; lap++) begin
      for (int i = 0; i < NS; i++) begin
        int d;
        d = units(int'(TUNE_A[i][4:2])) * 1 * (PRE_DIV * 2);
        check("R1 R2 step pitch", int'(pitch), int'(TUNE_A[i][10:6]));
        check("R6 note_on", int'(note_on), int'(TUNE_A[i][0]));
        check("R6 rest_on", int'(rest_on), int'(!TUNE_A[i][0]));
        check("R7 strike at step start", int'(strike), int'(TUNE_A[i][1]));
        if (lap == 0 && i == 0) begin
          tune_sel = 4'd3; tempo_code = 5'd7; div_sel = 1'b1;  // R10: ignored while playing
        end
        negs(d + 1);
        check("R3 R10 pitch held to last cycle", int'(pitch), int'(TUNE_A[i][10:6]));
        check("R7 tie keeps note_on", int'(note_on), int'(TUNE_A[i][0]));
        check("R7 strike low at step end", int'(strike), 0);
        negs(i == NS - 1 ? 3 : 1);   // R8: end marker adds 2 cycles
      end
    end
    play = 1'b0;
    negs(1);
    check("R9 stop pitch", int'(pitch), 0);
    check("R9 stop note_on", int'(note_on), 0);
    check("R9 stop strike", int'(strike), 0);
    negs(1);

    start(3, 2, 1'b0);
    check("R5 first strike", int'(strike), 1);
    negs(27);
    check("R5 note held before repeat", int'(note_on), 1);
    check("R5 no early strike", int'(strike), 0);
    negs(1);
    check("R5 R8 repeat strike", int'(strike), 1);
    check("R8 repeat pitch", int'(pitch), 3);
    stop_play();

    start(3, 0, 1'b1);
    check("R4 first strike", int'(strike), 1);
    negs(19);
    check("R4 no early strike", int'(strike), 0);
    negs(1);
    check("R4 repeat strike", int'(strike), 1);
    stop_play();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule